// File: doc/BRIEF.md
# Burst-Code Transcode and Parity Encoder

This block sits on the transmit side of a 64B/66B serial link. It accepts one 66-bit line block per clock, with a valid/ready handshake. Each block becomes a 65-bit word. The 2-bit sync header is reduced to a single transcode bit. That bit is formed from the surviving header bit and one payload bit, which keeps the line pattern DC-balanced. The 64 payload bits pass through untouched.

Thirty-two such words make up the message part of a 2112-bit code block. The parity is 32 bits of a shortened cyclic burst-correcting code. A linear feedback shift register computes it over the message, taking one 65-bit word per clock. After the last message word the parity goes out as a separate word. While the parity is emitted, the block holds its ready output low for exactly one cycle so that no input block is dropped. A start marker flags the first message word of every code block. The scrambler, gearbox and serializer that follow are separate blocks.

Top module: `fcode_tx_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, and afterwards until a block is accepted, `out_valid`, `out_sof` and `out_is_parity` are 0 and `in_ready` is 1. The first block accepted after reset opens a new code block.
- R2: For a message word, `out_data[64:1]` equals payload bits D0..D63, taken from `in_blk[65:2]` (D0 in `in_blk[2]`). The first header bit S0 (`in_blk[0]`) has no effect on any output.
- R3: `out_data[0]`, the bit sent first, equals S1 (`in_blk[1]`) XOR payload bit D8 (`in_blk[10]`).
- R4: A block accepted at a clock edge (`in_valid` and `in_ready` both 1) appears on `out_data` with `out_valid` = 1 directly after that edge, for one cycle.
- R5: `out_sof` is 1 with the first of the 32 message words of each code block and 0 on every other output.
- R6: After the 32nd message word is accepted, `in_ready` is 0 for exactly one cycle. A block offered in that cycle is not taken. After that cycle's edge the parity word appears with `out_valid` = 1, `out_is_parity` = 1, the parity in `out_data[31:0]` and `out_data[64:32]` = 0.
- R7: The parity is the remainder of x^32·M(x) divided by g(x) = x^32+x^23+x^21+x^11+x^2+1. M(x) is the 2080 message bits in send order (bit 0 of word 0 first, as the highest-degree term). `out_data[0]` of the parity word holds the x^31 coefficient and `out_data[31]` holds the x^0 coefficient.
- R8: The parity of each code block depends only on that block's own 32 words. The register restarts from zero at every block boundary.
- R9: Cycles with `in_valid` low produce no output (`out_valid` = 0) and do not advance the word count or change the parity state.
- R10: A synchronous reset in the middle of a block discards the partial block. The next accepted word carries `out_sof`, and the parity that follows covers only words sent after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input line block present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_blk | input | 66 | Line block: [1:0] sync header S0,S1; [65:2] payload D0..D63 |
| out_valid | output | 1 | Output word present |
| out_data | output | 65 | Transcoded word, or parity in [31:0] |
| out_sof | output | 1 | First message word of a code block |
| out_is_parity | output | 1 | Output word is the parity word |

## Verification
The hardest state to reach is the parity turnaround. Only the 32nd accepted word gets there, and the bench must then still be offering data while `in_ready` drops. The bench therefore sends whole code blocks and keeps `in_valid` high with a decoy block through the stall cycle. It then checks that the decoy never shows up. A second back-to-back block proves the parity register restarts. A block with idle holes in the middle shows that gaps do not shift the framing, and a reset after five words shows that a partial block is dropped. Table entries with both header polarities, including illegal ones differing only in S0, pin down the transcode bit.

// File: rtl/fcenc_pkg.sv
// Package: shared parameters and the unrolled parity update for the encoder.
// Assumes the message enters the divider LSB-first within a word (bit 0 sent first).
package fcenc_pkg;
    localparam int PAY_W   = 64;
    localparam int WORD_W  = PAY_W + 1;
    localparam int BLK_W   = PAY_W + 2;
    localparam int PAR_W   = 32;
    localparam logic [PAR_W-1:0] GEN_POLY = 32'h00A0_0805;

    // Feed one WORD_W word through the divider, one bit per step, bit 0 first.
    function automatic logic [PAR_W-1:0] par_step(input logic [PAR_W-1:0] rem,
                                                  input logic [WORD_W-1:0] w);
        logic [PAR_W-1:0] r;
        logic fb;
        r = rem;
        for (int i = 0; i < WORD_W; i++) begin
            fb = w[i] ^ r[PAR_W-1];
            r  = {r[PAR_W-2:0], 1'b0} ^ (fb ? GEN_POLY : '0);
        end
        return r;
    endfunction
endpackage

// File: rtl/fcenc_transcode.sv
// Transcoder: drops sync bit S0 and forms the transcode bit from S1 and D8.
// Assumes in_blk[1:0] = {S1,S0} and in_blk[65:2] = D63..D0.
module fcenc_transcode #(
    parameter int PAY_W = 64,
    parameter int TAP   = 8,
    localparam int BLK_W  = PAY_W + 2,
    localparam int WORD_W = PAY_W + 1
) (
    input  logic [BLK_W-1:1]  blk_hi,
    output logic [WORD_W-1:0] word
);
    // Combine the kept header bit with the balancing payload tap.
    always_comb begin
        word = {blk_hi[BLK_W-1:2], blk_hi[1] ^ blk_hi[TAP+2]};
    end
endmodule

// File: rtl/fcenc_parity_lfsr.sv
// Parity register: accumulates the cyclic-code remainder over a block.
// Assumes adv and clr are never high together; clr ends the parity cycle.
module fcenc_parity_lfsr
    import fcenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              clr,
    input  logic [WORD_W-1:0] word,
    output logic [PAR_W-1:0]  parity
);
    logic [PAR_W-1:0] rem;

    // Update the remainder by one word, clear at block end, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) rem <= '0;
        else if (adv)      rem <= par_step(rem, word);
    end

    // Highest-degree coefficient is transmitted first (bit 0).
    genvar g;
    generate
        for (g = 0; g < PAR_W; g++) begin : g_rev
            assign parity[g] = rem[PAR_W-1-g];
        end
    endgenerate

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(rem)); // R9
endmodule

// File: rtl/fcenc_framer.sv
// Framer: counts message words and inserts the one-cycle parity slot.
// Assumes the downstream always takes output (no output backpressure).
module fcenc_framer #(
    parameter int WORDS = 32,
    localparam int CNT_W = $clog2(WORDS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic accept,
    output logic first,
    output logic par_slot
);
    logic [CNT_W-1:0] cnt;

    assign in_ready = !par_slot;
    assign accept   = in_valid && in_ready;
    assign first    = (cnt == '0);

    // Advance the word count per accepted block; arm the parity slot after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            par_slot <= 1'b0;
        end else if (par_slot) begin
            par_slot <= 1'b0;
        end else if (accept) begin
            if (cnt == CNT_W'(WORDS-1)) begin
                cnt      <= '0;
                par_slot <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_SLOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        par_slot |=> !par_slot); // R6
endmodule

// File: rtl/fcode_tx_encoder.sv
// Top: transcode + systematic parity encoder producing 2112-bit code blocks.
// Assumes a 64B/66B block stream in; emits 32 message words then one parity word.
module fcode_tx_encoder
    import fcenc_pkg::*;
#(
    parameter int WORDS = 32,
    parameter int TAP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [65:0]       in_blk,
    output logic              out_valid,
    output logic [64:0]       out_data,
    output logic              out_sof,
    output logic              out_is_parity
);
    logic              accept, first, par_slot;
    logic [WORD_W-1:0] tword;
    logic [PAR_W-1:0]  parity;
    logic              unused_s0;

    assign unused_s0 = in_blk[0];

    fcenc_framer #(.WORDS(WORDS)) u_frm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .accept(accept), .first(first), .par_slot(par_slot)
    );

    fcenc_transcode #(.PAY_W(PAY_W), .TAP(TAP)) u_tc (
        .blk_hi(in_blk[BLK_W-1:1]), .word(tword)
    );

    fcenc_parity_lfsr u_par (
        .clk(clk), .rst_n(rst_n), .adv(accept), .clr(par_slot),
        .word(tword), .parity(parity)
    );

    // Register the outgoing word: message word on accept, parity in the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_sof       <= 1'b0;
            out_is_parity <= 1'b0;
            out_data      <= '0;
        end else begin
            out_valid     <= accept || par_slot;
            out_sof       <= accept && first;
            out_is_parity <= par_slot;
            out_data      <= par_slot ? {{(WORD_W-PAR_W){1'b0}}, parity} : tword;
        end
    end

    AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_parity) |-> out_data[64:1] == $past(in_blk[65:2])); // R2
    AST_PARITY_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_parity |-> ($past(!in_ready) && out_valid)); // R6
    AST_NO_SOF_ON_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_parity |-> !out_sof); // R5
    AST_PARITY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_parity |-> out_data[64:32] == '0); // R6
endmodule

// File: tb/fcode_tx_encoder_test.sv
module fcode_tx_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [65:0] in_blk = '0;
    logic        in_ready, out_valid, out_sof, out_is_parity;
    logic [64:0] out_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk; // 50 MHz

    fcode_tx_encoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_blk(in_blk), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_is_parity(out_is_parity)
    );

    // {expected transcode bit, payload D63..D0, S1, S0}
    localparam logic [66:0] VEC [8] = '{
        {1'b1, 64'h0000_0000_0000_0000, 1'b1, 1'b0},
        {1'b0, 64'h0000_0000_0000_0100, 1'b1, 1'b0},
        {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1},
        {1'b0, 64'hFFFF_FFFF_FFFF_FEFF, 1'b0, 1'b1},
        {1'b0, 64'hA5A5_A5A5_A5A5_A5A5, 1'b1, 1'b0},
        {1'b0, 64'h5A5A_5A5A_5A5A_5A5A, 1'b0, 1'b1},
        {1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0},
        {1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1}
    };

    logic [64:0] sent [32];

    task automatic chk(input logic ok, input string req, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Serial long division of the 2080 sent bits by g(x).
    function automatic logic [31:0] ref_parity();
        logic [31:0] r = '0;
        logic [31:0] p;
        logic fb;
        for (int j = 0; j < 32; j++)
            for (int b = 0; b < 65; b++) begin
                fb = sent[j][b] ^ r[31];
                r  = {r[30:0], 1'b0};
                if (fb) r = r ^ ((32'd1 << 23) | (32'd1 << 21) | (32'd1 << 11) | (32'd1 << 2) | 32'd1);
            end
        for (int i = 0; i < 32; i++) p[i] = r[31-i];
        return p;
    endfunction

    // Send one block and check the output word that follows (R2, R3, R4, R5).
    task automatic send(input logic [66:0] v, input int j, input int k);
        logic [65:0] blk;
        logic [64:0] exp;
        blk = v[65:0] ^ (66'(j * 7 + k * 13 + 1) << 20);
        exp = {blk[65:2], v[66]};
        in_valid = 1'b1; in_blk = blk;
        @(negedge clk);
        sent[j] = exp;
        chk(out_valid && !out_is_parity, "R4 valid", {63'b0, out_valid, out_is_parity}, 65'b10);
        chk(out_data[64:1] == exp[64:1], "R2 payload", out_data, exp);
        chk(out_data[0] == exp[0], "R3 tcode", {64'b0, out_data[0]}, {64'b0, exp[0]});
        chk(out_sof == (j == 0), "R5 sof", {64'b0, out_sof}, {64'b0, j == 0});
    endtask

    // Parity slot: stall with a decoy offered, then check the parity word (R6, R7).
    task automatic finish_block();
        logic [31:0] p;
        chk(!in_ready, "R6 ready low", {64'b0, in_ready}, 65'b0);
        in_valid = 1'b1; in_blk = {64'hDEAD_BEEF_DEAD_BEEF, 2'b01};
        @(negedge clk);
        p = ref_parity();
        chk(out_valid && out_is_parity && !out_sof, "R6 parity flags",
            {62'b0, out_valid, out_is_parity, out_sof}, 65'b110);
        chk(out_data == {33'b0, p}, "R7 parity", out_data, {33'b0, p});
        chk(in_ready, "R6 ready back", {64'b0, in_ready}, 65'b1);
        in_valid = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_sof && !out_is_parity && in_ready, "R1 reset",
            {61'b0, out_valid, out_sof, out_is_parity, in_ready}, 65'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R1 idle", {64'b0, out_valid}, 65'b0);

        // Table walk: two back-to-back code blocks (R8 for the second).
        for (int k = 0; k < 2; k++) begin
            for (int j = 0; j < 32; j++) send(VEC[j % 8], j, k);
            finish_block();
        end
        @(negedge clk);
        chk(!out_valid, "R6 decoy dropped", {64'b0, out_valid}, 65'b0);

        // S0 flip only: same output word (R2).
        in_valid = 1'b1; in_blk = {VEC[6][65:1], 1'b0};
        @(negedge clk);
        begin
            logic [64:0] a;
            a = out_data;
            chk(out_sof, "R5 sof after parity", {64'b0, out_sof}, 65'b1);
            in_blk = {VEC[6][65:1], 1'b1};
            @(negedge clk);
            chk(out_data == a, "R2 S0 ignored", out_data, a);
        end
        in_valid = 1'b0;

        // Mid-block reset after a partial block (R10).
        for (int j = 0; j < 3; j++) send(VEC[j], j + 2, 5);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, "R10 reset clears", {63'b0, out_valid, in_ready}, 65'b01);

        // Block with idle gaps (R9), checked against reference parity (R10).
        for (int j = 0; j < 32; j++) begin
            send(VEC[(j + 3) % 8], j, 9);
            if (j % 5 == 2) begin
                in_valid = 1'b0;
                @(negedge clk);
                chk(!out_valid, "R9 gap", {64'b0, out_valid}, 65'b0);
                @(negedge clk);
                chk(!out_valid, "R9 gap", {64'b0, out_valid}, 65'b0);
            end
        end
        finish_block();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule